// File: doc/BRIEF.md
# External control word transfer unit

This unit takes one user-level external-control request at a time, either an input transfer (read a word from a special-purpose device) or an output transfer (write a word to it), and turns it into a single request/acknowledge bus transaction. Address translation happens upstream. The unit receives the effective address, the translated physical address, the segment direct-store flag and the data-relocation mode. It also receives the external-access configuration register and, for writes, the store data.

The unit repurposes two sideband fields to carry a 4-bit resource identifier to the device. The burst line carries the top bit of the identifier and the three transfer-size lines carry the lower three bits. The transfer is always exactly one 32-bit word. Before any bus activity, the unit screens the request for two faults: a word-misaligned address and an access to a direct-store segment. Either fault is reported with a done pulse and no transaction is issued.

With data relocation off, the access is a programming error. The bus address is then unspecified (this design drives the effective address), but the transfer still runs to completion.

Top module: `ext_ctl_xfer_unit`

## Requirements
- R1: On every issued transaction, `bus_burst` equals configuration bit 3 and `bus_size[2:0]` equals configuration bits 2..0; configuration bits above bit 3 have no effect.
- R2: A request whose effective address has bits 1..0 not both zero raises `exc_align` together with `rsp_done` in the cycle after acceptance, and `bus_req` stays low.
- R3: A word-aligned request with `seg_direct`=1 raises `exc_dsi` together with `rsp_done` in the cycle after acceptance, and `bus_req` stays low.
- R4: When both faults of R2 and R3 apply, only `exc_align` is raised; `exc_align` and `exc_dsi` are never high together.
- R5: A fault-free request is accepted on the clock edge where `req_valid` and `req_ready` are both high; `bus_req` is high from the next cycle, and with `dr_mode`=1 `bus_addr` equals the physical address.
- R6: With `dr_mode`=0, a fault-free request still raises `bus_req` and finishes with `rsp_done` after acknowledge; no exception is flagged.
- R7: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_addr`, `bus_size`, `bus_burst`, `bus_write` and `bus_wdata` hold their values into the next cycle.
- R8: In the cycle after the edge that samples `bus_ack` high, `bus_req` is low and `rsp_done` is high for one cycle; for a read, `rsp_rdata` then equals the `bus_rdata` value sampled on that edge.
- R9: `bus_write` is 1 for an output transfer (`req_write`=1) and 0 for an input transfer; for an output transfer `bus_wdata` equals the store data presented at acceptance.
- R10: `req_ready` is low while a bus transaction is outstanding, and a `req_valid` presented in that time is not accepted and starts no further transaction.
- R11: After reset `bus_req`, `rsp_done`, `exc_align` and `exc_dsi` are low and `req_ready` is high.
- R12: An output transfer leaves `rsp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_write | input | 1 | 1 = output (write) transfer, 0 = input (read) |
| req_ea | input | AW | Effective address |
| req_pa | input | AW | Translated physical address |
| seg_direct | input | 1 | Segment is marked direct-store |
| dr_mode | input | 1 | Data relocation enabled |
| cfg_ext | input | CW | External-access configuration register; bits 3..0 hold the resource ID |
| req_wdata | input | DW | Store data for output transfers |
| bus_req | output | 1 | Bus transaction request |
| bus_ack | input | 1 | Bus acknowledge |
| bus_addr | output | AW | Bus address |
| bus_size | output | 3 | Size lines, carrying resource ID bits 2..0 |
| bus_burst | output | 1 | Burst line, carrying resource ID bit 3 |
| bus_write | output | 1 | Transfer direction, 1 = write |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with acknowledge |
| rsp_done | output | 1 | One-cycle completion or exception pulse |
| rsp_rdata | output | DW | Data of the last completed read |
| exc_align | output | 1 | Alignment exception, with `rsp_done` |
| exc_dsi | output | 1 | Data storage exception, with `rsp_done` |

## Verification
The bench sets configuration words with the upper bits filled and the lower nibble varied. A unit that decoded the wrong field, or swapped the burst bit with a size bit, would put a different resource ID on the bus. Misaligned addresses are tried both alone and combined with direct-store segments: a wrong priority would show both flags or the storage flag, and a weak check would let a transaction leak onto the bus. Acknowledge is held back for several cycles so that any drift in the address, sideband or data before acknowledge is caught. Further stimuli cover a relocation-off access, which a careless design might abort, a request presented while the unit is busy, which must not be taken, and a write, which must leave the read result untouched.

// File: rtl/ecx_pkg.sv
package ecx_pkg;
  localparam int RID_W  = 4;
  localparam int SIZE_W = 3;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } ecx_state_e;

  typedef struct packed {
    logic              burst;
    logic [SIZE_W-1:0] size;
  } ecx_side_t;

  // resource ID most significant bit rides on burst, the rest on size
  function automatic ecx_side_t rid_to_side(input logic [RID_W-1:0] rid);
    ecx_side_t s;
    s.burst = rid[RID_W-1];
    s.size  = rid[SIZE_W-1:0];
    return s;
  endfunction

  function automatic logic word_misaligned(input logic [1:0] low_bits);
    return low_bits != 2'b00;
  endfunction
endpackage

// File: rtl/ecx_check.sv
module ecx_check
  import ecx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ea,
  input  logic          seg_direct,
  output logic          fault_align,
  output logic          fault_dsi
);
  always_comb begin
    fault_align = word_misaligned(ea[1:0]);
    // storage fault only reported when alignment is clean
    fault_dsi   = seg_direct && !fault_align;
  end

  always_comb begin
    // R4
    excl_fault_chk: assert (!(fault_align && fault_dsi));
  end
endmodule

// File: rtl/ecx_encode.sv
module ecx_encode
  import ecx_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic [CW-1:0]     cfg,
  output logic              burst,
  output logic [SIZE_W-1:0] size
);
  ecx_side_t side;

  always_comb begin
    side  = rid_to_side(cfg[RID_W-1:0]);
    burst = side.burst;
    size  = side.size;
  end
endmodule

// File: rtl/ext_ctl_xfer_unit.sv
module ext_ctl_xfer_unit
  import ecx_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_ea,
  input  logic [AW-1:0]     req_pa,
  input  logic              seg_direct,
  input  logic              dr_mode,
  input  logic [CW-1:0]     cfg_ext,
  input  logic [DW-1:0]     req_wdata,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic [AW-1:0]     bus_addr,
  output logic [SIZE_W-1:0] bus_size,
  output logic              bus_burst,
  output logic              bus_write,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  output logic              rsp_done,
  output logic [DW-1:0]     rsp_rdata,
  output logic              exc_align,
  output logic              exc_dsi
);
  ecx_state_e        state_q;
  logic              accept;
  logic              xfer_end;
  logic              fault_align;
  logic              fault_dsi;
  logic              enc_burst;
  logic [SIZE_W-1:0] enc_size;
  logic [AW-1:0]     sel_addr;

  ecx_check #(.AW(AW)) u_check (
    .ea          (req_ea),
    .seg_direct  (seg_direct),
    .fault_align (fault_align),
    .fault_dsi   (fault_dsi)
  );

  ecx_encode #(.CW(CW)) u_encode (
    .cfg   (cfg_ext),
    .burst (enc_burst),
    .size  (enc_size)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign xfer_end  = (state_q == ST_BUS) && bus_ack;
  // relocation off: address undefined, the untranslated one is driven
  assign sel_addr  = dr_mode ? req_pa : req_ea;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bus_req   <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_burst <= 1'b0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      exc_align <= 1'b0;
      exc_dsi   <= 1'b0;
    end else begin
      rsp_done  <= 1'b0;
      exc_align <= 1'b0;
      exc_dsi   <= 1'b0;
      if (accept) begin
        if (fault_align) begin
          rsp_done  <= 1'b1;
          exc_align <= 1'b1;
        end else if (fault_dsi) begin
          rsp_done  <= 1'b1;
          exc_dsi   <= 1'b1;
        end else begin
          state_q   <= ST_BUS;
          bus_req   <= 1'b1;
          bus_addr  <= sel_addr;
          bus_size  <= enc_size;
          bus_burst <= enc_burst;
          bus_write <= req_write;
          bus_wdata <= req_write ? req_wdata : '0;
        end
      end
      if (xfer_end) begin
        state_q  <= ST_IDLE;
        bus_req  <= 1'b0;
        rsp_done <= 1'b1;
        if (!bus_write) rsp_rdata <= bus_rdata;
      end
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size)
      && $stable(bus_burst) && $stable(bus_write) && $stable(bus_wdata));

  // R4
  one_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_align && exc_dsi));

  // R2
  align_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fault_align |=> !bus_req && exc_align && rsp_done);

  // R3
  dsi_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fault_dsi |=> !bus_req && exc_dsi && rsp_done);

  // R8
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> rsp_done && !bus_req);

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready);

  // R5
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(accept));
endmodule

// File: tb/ext_ctl_xfer_unit_bench.sv
module ext_ctl_xfer_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_ea = '0;
  logic [31:0] req_pa = '0;
  logic        seg_direct = 1'b0;
  logic        dr_mode = 1'b1;
  logic [31:0] cfg_ext = '0;
  logic [31:0] req_wdata = '0;
  logic        bus_req;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_addr;
  logic [2:0]  bus_size;
  logic        bus_burst;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        exc_align;
  logic        exc_dsi;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] last_rd = '0;

  always #2 clk = ~clk;

  ext_ctl_xfer_unit u_ext_ctl_xfer_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_ea(req_ea), .req_pa(req_pa),
    .seg_direct(seg_direct), .dr_mode(dr_mode), .cfg_ext(cfg_ext),
    .req_wdata(req_wdata), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_burst(bus_burst),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .exc_align(exc_align),
    .exc_dsi(exc_dsi)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] ea;
    logic [31:0] pa;
    logic        sd;
    logic        dr;
    logic [31:0] cfg;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [3:0]  dly;
    logic [1:0]  exc;  // 0 none, 1 alignment, 2 storage
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 32'h0000_1000, 32'h8000_1000, 1'b0, 1'b1, 32'h0000_0005, 32'h0, 32'hCAFE_0001, 4'd0, 2'd0},
    '{1'b1, 32'h0000_2004, 32'h9000_2004, 1'b0, 1'b1, 32'hFFFF_FFFA, 32'h1234_5678, 32'hDEAD_0000, 4'd2, 2'd0},
    '{1'b0, 32'h0000_3002, 32'h0000_3002, 1'b0, 1'b1, 32'h0000_0003, 32'h0, 32'h0, 4'd0, 2'd1},
    '{1'b1, 32'h0000_3008, 32'h4000_3008, 1'b1, 1'b1, 32'h0000_0009, 32'h1111_1111, 32'h0, 4'd0, 2'd2},
    '{1'b0, 32'h0000_3001, 32'h4000_3001, 1'b1, 1'b1, 32'h0000_0001, 32'h0, 32'h0, 4'd0, 2'd1},
    '{1'b0, 32'h0000_4000, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0008, 32'h0, 32'h5555_AAAA, 4'd3, 2'd0},
    '{1'b1, 32'h0000_5010, 32'hA000_5010, 1'b0, 1'b1, 32'h0000_000F, 32'h0BAD_F00D, 32'h7777_7777, 4'd1, 2'd0},
    '{1'b0, 32'h0000_6FFC, 32'hB000_6FFC, 1'b0, 1'b1, 32'h0000_00F0, 32'h0, 32'h0123_4567, 4'd5, 2'd0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] a0;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_ea = v.ea; req_pa = v.pa;
    seg_direct = v.sd; dr_mode = v.dr; cfg_ext = v.cfg; req_wdata = v.wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (v.exc != 2'd0) begin
      check(rsp_done == 1'b1, v.exc == 2'd1 ? "R2 done" : "R3 done", rsp_done, 1);
      check(bus_req == 1'b0, "R2/R3 no bus", bus_req, 0);
      check(exc_align == (v.exc == 2'd1), "R4 align flag", exc_align, v.exc == 2'd1);
      check(exc_dsi == (v.exc == 2'd2), "R3 storage flag", exc_dsi, v.exc == 2'd2);
      @(posedge clk); #1;
      check(bus_req == 1'b0 && rsp_done == 1'b0, "R2 quiet after", {bus_req, rsp_done}, 0);
      return;
    end
    check(bus_req == 1'b1, "R5 request", bus_req, 1);
    if (v.dr) check(bus_addr == v.pa, "R5 address", bus_addr, v.pa);
    check({bus_burst, bus_size} == v.cfg[3:0], "R1 resource id", {bus_burst, bus_size}, v.cfg[3:0]);
    check(bus_write == v.wr, "R9 direction", bus_write, v.wr);
    if (v.wr) check(bus_wdata == v.wd, "R9 write data", bus_wdata, v.wd);
    check(req_ready == 1'b0, "R10 busy", req_ready, 0);
    a0 = bus_addr;
    for (int i = 0; i < int'(v.dly); i++) begin
      @(posedge clk); #1;
      check(bus_req == 1'b1 && bus_addr == a0 && {bus_burst, bus_size} == v.cfg[3:0],
            "R7 hold", {bus_req, bus_addr}, {1'b1, a0});
    end
    @(negedge clk);
    bus_ack = 1'b1; bus_rdata = v.rd;
    @(posedge clk); #1;
    bus_ack = 1'b0; bus_rdata = 32'hFFFF_0000;
    check(bus_req == 1'b0 && rsp_done == 1'b1, v.dr ? "R8 end" : "R6 completes",
          {bus_req, rsp_done}, 2'b01);
    check(exc_align == 1'b0 && exc_dsi == 1'b0, "R6 no exception", {exc_align, exc_dsi}, 0);
    if (!v.wr) last_rd = v.rd;
    check(rsp_rdata == last_rd, v.wr ? "R12 read data kept" : "R8 read data", rsp_rdata, last_rd);
  endtask

  initial begin
    #(4 * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(bus_req == 1'b0 && rsp_done == 1'b0 && exc_align == 1'b0 && exc_dsi == 1'b0,
          "R11 reset outputs", {bus_req, rsp_done, exc_align, exc_dsi}, 0);
    check(req_ready == 1'b1, "R11 ready", req_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R10: second request during an open transaction is not taken
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_ea = 32'h0000_7000; req_pa = 32'hC000_7000;
    seg_direct = 1'b0; dr_mode = 1'b1; cfg_ext = 32'h2;
    @(posedge clk); #1;
    req_ea = 32'h0000_7100; req_pa = 32'hC000_7100; cfg_ext = 32'hC;
    repeat (2) @(posedge clk);
    #1;
    check(bus_addr == 32'hC000_7000 && {bus_burst, bus_size} == 4'h2,
          "R10 not re-accepted", bus_addr, 32'hC000_7000);
    @(negedge clk);
    req_valid = 1'b0; bus_ack = 1'b1; bus_rdata = 32'h2468_ACE0;
    @(posedge clk); #1;
    bus_ack = 1'b0;
    check(rsp_done == 1'b1 && rsp_rdata == 32'h2468_ACE0, "R8 busy read", rsp_rdata, 32'h2468_ACE0);
    @(posedge clk); #1;
    check(bus_req == 1'b0 && rsp_done == 1'b0, "R10 no extra transaction", {bus_req, rsp_done}, 0);

    finish_run();
  end
endmodule